// File: doc/BRIEF.md
# Output Channel Source Selector

This block produces the on/off enables for ten low-side switch channels. Every channel owns a 2-bit source code that picks one of four drivers:
- the channel's direct input pin;
- the channel's bit in a serially written output register;
- a static level held in the pairing register;
- the AND of the register bit and the pin.

Adjacent channels form pairs (1/2, 3/4, 5/6, 7/8, 9/10). A tie bit per pair makes the upper channel copy the lower channel's selected value, so two switches wired in parallel act as one.

A serial command decoder, outside this block, writes the configuration through one-cycle load strobes that share a data bus. Loads only fill a staging copy. A separate strobe, raised once per frame when chip select rises, moves every staged value into the active copy at the same time.

An enable input drops all outputs without touching any register. After enable returns, the outputs stay off for a programmable number of clock cycles. A fault block can force single channels off. An asynchronous active-low reset returns every register to its default.

Top module: `chan_src_sel`

## Requirements
- R1: While reset is low, `ch_on` is all zeros. Reset leaves every source code at 00, the output register at 0 and the pairing register at 0.
- R2: Source code 00 drives the channel from its input pin. `ch_on[k]` equals `in_pin[k]` one clock edge later.
- R3: Source code 01 drives the channel from bit k of the output register, where 1 means on. The register resets to 0, so moving a channel into code 01 with no register write turns it off.
- R4: Source code 10 drives both channels of pair p from `wr_data` bit 2p of the pairing register, the pair's static level.
- R5: Source code 11 drives the channel from the AND of its output-register bit and its input pin.
- R6: Loads change only the staged copy and have no effect on `ch_on` until `cs_rise`. A `cs_rise` pulse moves all staged registers into the active copy together. The new selection shows on `ch_on` at the second clock edge after the pulse is sampled.
- R7: Field layouts on `wr_data`:
  - `ld_mode_a` writes the codes of channels 1 to 6, with channel i in bits [2i-1:2i-2].
  - `ld_mode_b` writes channels 7 to 10, with channel 7+j in bits [2j+1:2j].
  - `ld_out` writes bit k-1 for channel k.
- R8: When pairing bit 2p+1 is set, channel 2p+2 copies the selected value of channel 2p+1, which uses its own source code and pin. Example: with channel 3 on pin mode and its pin low, channel 4 turns off.
- R9: `en` low forces every output off at the next edge. All register contents are kept, and the previous selection returns once enable has resumed.
- R10: After `en` is high, or after reset is released, the outputs stay off for RESUME_CYC clock edges. They follow the selection from edge RESUME_CYC+1 onward.
- R11: `fault_off[k]` forces channel k off at the next edge and leaves the other channels unchanged.
- R12: A reset during operation clears both the active and the staged registers. A later `cs_rise` with no loads keeps every channel on pin mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Output enable; low forces all channels off |
| in_pin | input | N_CH | Direct input pins, bit k for channel k+1 |
| fault_off | input | N_CH | Per-channel forced shutdown from the fault block |
| ld_mode_a | input | 1 | Stage source codes for the lower channel group |
| ld_mode_b | input | 1 | Stage source codes for the upper channel group |
| ld_out | input | 1 | Stage the output register |
| ld_par | input | 1 | Stage the pairing register (level and tie per pair) |
| wr_data | input | WR_W | Write data shared by all load strobes |
| cs_rise | input | 1 | Commit strobe; all staged values become active |
| ch_on | output | N_CH | Registered switch enables |

## Verification
The hardest case to reach is a pair tie combined with pin mode on the lower channel, where the upper channel must turn off even though its own pin is high. The stimulus first commits pin mode with the tie bit set. It then drives the two pins of the pair in opposite directions in both orders, so that any dependence on the upper channel's own pin shows at the ports. A second hard case is the staging: loads are written and the outputs are watched for several cycles before the commit. Two loads are also committed by one strobe.

// File: rtl/chan_src_pkg.sv
package chan_src_pkg;

    typedef enum logic [1:0] {
        SRC_PIN = 2'b00,
        SRC_REG = 2'b01,
        SRC_LVL = 2'b10,
        SRC_AND = 2'b11
    } src_mode_e;

    function automatic logic pick_src(input logic [1:0] code,
                                      input logic pin,
                                      input logic reg_bit,
                                      input logic lvl);
        case (src_mode_e'(code))
            SRC_PIN: pick_src = pin;
            SRC_REG: pick_src = reg_bit;
            SRC_LVL: pick_src = lvl;
            default: pick_src = reg_bit & pin;
        endcase
    endfunction

endpackage

// File: rtl/chan_src_regs.sv
module chan_src_regs #(
    parameter int N_CH  = 10,
    parameter int GRP_A = 6,
    parameter int WR_W  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_mode_a,
    input  logic                 ld_mode_b,
    input  logic                 ld_out,
    input  logic                 ld_par,
    input  logic [WR_W-1:0]      wr_data,
    input  logic                 commit,
    output logic [2*N_CH-1:0]    mode_vec,
    output logic [N_CH-1:0]      out_reg,
    output logic [N_CH-1:0]      par_reg
);
    localparam int MA_W   = 2 * GRP_A;
    localparam int MB_W   = 2 * (N_CH - GRP_A);
    localparam int MODE_W = 2 * N_CH;

    typedef struct packed {
        logic [MODE_W-1:0] stg_mode;
        logic [N_CH-1:0]   stg_out;
        logic [N_CH-1:0]   stg_par;
        logic [MODE_W-1:0] act_mode;
        logic [N_CH-1:0]   act_out;
        logic [N_CH-1:0]   act_par;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld_mode_a) st_d.stg_mode[MA_W-1:0]      = wr_data[MA_W-1:0];
        if (ld_mode_b) st_d.stg_mode[MODE_W-1:MA_W] = wr_data[MB_W-1:0];
        if (ld_out)    st_d.stg_out                 = wr_data[N_CH-1:0];
        if (ld_par)    st_d.stg_par                 = wr_data[N_CH-1:0];
        if (commit) begin
            st_d.act_mode = st_q.stg_mode;
            st_d.act_out  = st_q.stg_out;
            st_d.act_par  = st_q.stg_par;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mode_vec = st_q.act_mode;
    assign out_reg  = st_q.act_out;
    assign par_reg  = st_q.act_par;

    // R6: active copy only moves on a commit
    p_hold_no_commit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({mode_vec, out_reg, par_reg}));

    // R6: a commit copies the staged values as they stood before the edge
    p_commit_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> ({mode_vec, out_reg, par_reg} ==
                    $past({st_q.stg_mode, st_q.stg_out, st_q.stg_par})));

endmodule

// File: rtl/chan_src_mux.sv
module chan_src_mux #(
    parameter int N_CH = 10
) (
    input  logic [2*N_CH-1:0] mode_vec,
    input  logic [N_CH-1:0]   out_reg,
    input  logic [N_CH-1:0]   par_reg,
    input  logic [N_CH-1:0]   pin,
    output logic [N_CH-1:0]   sel
);
    import chan_src_pkg::*;

    localparam int N_PAIR = N_CH / 2;

    logic [N_CH-1:0] raw;

    for (genvar k = 0; k < N_CH; k++) begin : g_ch
        assign raw[k] = pick_src(mode_vec[2*k +: 2], pin[k], out_reg[k],
                                 par_reg[2*(k/2)]);
    end

    for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
        assign sel[2*p]   = raw[2*p];
        assign sel[2*p+1] = par_reg[2*p+1] ? raw[2*p] : raw[2*p+1];
    end

endmodule

// File: rtl/chan_src_gate.sv
module chan_src_gate #(
    parameter int N_CH       = 10,
    parameter int RESUME_CYC = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [N_CH-1:0] sel,
    input  logic [N_CH-1:0] fault_off,
    output logic [N_CH-1:0] ch_on
);
    localparam int CW = $clog2(RESUME_CYC + 1);

    typedef struct packed {
        logic [CW-1:0]   wait_cnt;
        logic [N_CH-1:0] on;
    } gate_st_t;

    gate_st_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (!en) begin
            g_d.wait_cnt = CW'(RESUME_CYC);
            g_d.on       = '0;
        end else begin
            if (g_q.wait_cnt != '0) g_d.wait_cnt = g_q.wait_cnt - 1'b1;
            g_d.on = (g_q.wait_cnt == '0) ? (sel & ~fault_off) : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '{wait_cnt: CW'(RESUME_CYC), on: '0};
        else        g_q <= g_d;
    end

    assign ch_on = g_q.on;

    // R9: disable drops every channel at the next edge
    p_off_when_disabled_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (ch_on == '0));

    // R10: the first enabled edge never drives a channel
    p_no_instant_resume_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |=> (ch_on == '0));

    // R11: a forced-off channel is off one edge later
    p_fault_forces_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_off != '0) |=> ((ch_on & $past(fault_off)) == '0));

endmodule

// File: rtl/chan_src_sel.sv
module chan_src_sel #(
    parameter  int N_CH       = 10,
    parameter  int GRP_A      = 6,
    parameter  int RESUME_CYC = 16,
    localparam int WR_W       = (2 * GRP_A > N_CH) ? 2 * GRP_A : N_CH
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [N_CH-1:0] in_pin,
    input  logic [N_CH-1:0] fault_off,
    input  logic            ld_mode_a,
    input  logic            ld_mode_b,
    input  logic            ld_out,
    input  logic            ld_par,
    input  logic [WR_W-1:0] wr_data,
    input  logic            cs_rise,
    output logic [N_CH-1:0] ch_on
);
    logic [2*N_CH-1:0] mode_vec;
    logic [N_CH-1:0]   out_reg;
    logic [N_CH-1:0]   par_reg;
    logic [N_CH-1:0]   sel;

    chan_src_regs #(.N_CH(N_CH), .GRP_A(GRP_A), .WR_W(WR_W)) regs_i (
        .clk(clk), .rst_n(rst_n),
        .ld_mode_a(ld_mode_a), .ld_mode_b(ld_mode_b),
        .ld_out(ld_out), .ld_par(ld_par),
        .wr_data(wr_data), .commit(cs_rise),
        .mode_vec(mode_vec), .out_reg(out_reg), .par_reg(par_reg)
    );

    chan_src_mux #(.N_CH(N_CH)) mux_i (
        .mode_vec(mode_vec), .out_reg(out_reg), .par_reg(par_reg),
        .pin(in_pin), .sel(sel)
    );

    chan_src_gate #(.N_CH(N_CH), .RESUME_CYC(RESUME_CYC)) gate_i (
        .clk(clk), .rst_n(rst_n), .en(en),
        .sel(sel), .fault_off(fault_off), .ch_on(ch_on)
    );

endmodule

// File: tb/chan_src_sel_tb_top.sv
`timescale 1ns/1ps
module chan_src_sel_tb_top;
    localparam int R = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [9:0]  in_pin = '0;
    logic [9:0]  fault_off = '0;
    logic        ld_mode_a = 1'b0, ld_mode_b = 1'b0, ld_out = 1'b0, ld_par = 1'b0;
    logic [11:0] wr_data = '0;
    logic        cs_rise = 1'b0;
    logic [9:0]  ch_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    chan_src_sel #(.N_CH(10), .GRP_A(6), .RESUME_CYC(R)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .in_pin(in_pin), .fault_off(fault_off),
        .ld_mode_a(ld_mode_a), .ld_mode_b(ld_mode_b), .ld_out(ld_out), .ld_par(ld_par),
        .wr_data(wr_data), .cs_rise(cs_rise), .ch_on(ch_on)
    );

    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [9:0] exp);
        n_chk++;
        if (ch_on !== exp) begin
            n_bad++;
            $display("FAIL %s: ch_on=%03h expected=%03h", req, ch_on, exp);
        end
    endtask

    // kind: 0 mode A, 1 mode B, 2 output register, 3 pairing register
    task automatic load(input int kind, input logic [11:0] d);
        wr_data   = d;
        ld_mode_a = (kind == 0);
        ld_mode_b = (kind == 1);
        ld_out    = (kind == 2);
        ld_par    = (kind == 3);
        tick();
        {ld_mode_a, ld_mode_b, ld_out, ld_par} = '0;
    endtask

    task automatic commit();
        cs_rise = 1'b1;
        tick();
        cs_rise = 1'b0;
        tick();
    endtask

    task automatic t_reset_start();
        in_pin = 10'h3FF;
        tick(3);
        chk("R1 off in reset", 10'h000);
        rst_n = 1'b1;
        tick(R);
        chk("R10 still off after release", 10'h000);
        tick();
        chk("R10 resumes, R1 default pin mode", 10'h3FF);
    endtask

    task automatic t_direct_r2();
        in_pin = 10'h155; tick(); chk("R2 pins 155", 10'h155);
        in_pin = 10'h2AA; tick(); chk("R2 pins 2AA", 10'h2AA);
    endtask

    task automatic t_staged_r6();
        in_pin = 10'h3FF;
        load(0, 12'h555);
        tick(3);
        chk("R6 staged mode without commit", 10'h3FF);
        commit();
        chk("R3 R7 group A to register mode, reg cleared", 10'h3C0);
        load(2, 12'h015);
        tick(2);
        chk("R6 staged output register", 10'h3C0);
        commit();
        chk("R3 register bits 1,3,5 on", 10'h3D5);
    endtask

    task automatic t_and_r5();
        load(1, 12'h0FF);
        load(2, 12'h155);
        in_pin = 10'h1BF;
        commit();
        chk("R5 R7 group B AND mode", 10'h115);
    endtask

    task automatic t_level_r4();
        load(0, 12'hAAA);
        load(3, 12'h011);
        commit();
        chk("R4 pair level mode", 10'h133);
    endtask

    task automatic t_tie_r8();
        load(0, 12'h000);
        load(3, 12'h008);
        in_pin = 10'h3FB;
        commit();
        chk("R8 ch4 follows low ch3 pin", 10'h173);
        in_pin = 10'h3F7;
        tick();
        chk("R8 ch4 follows high ch3 pin", 10'h17F);
    endtask

    task automatic t_enable_r9();
        en = 1'b0;
        tick();
        chk("R9 disable forces off", 10'h000);
        tick(4);
        chk("R9 stays off while disabled", 10'h000);
        en = 1'b1;
        tick(R);
        chk("R10 off during resume wait", 10'h000);
        tick();
        chk("R9 R10 config retained after resume", 10'h17F);
    endtask

    task automatic t_fault_r11();
        fault_off = 10'h001;
        tick();
        chk("R11 channel 1 forced off", 10'h17E);
        fault_off = 10'h000;
        tick();
        chk("R11 channel 1 back after release", 10'h17F);
    endtask

    task automatic t_reset_clear_r12();
        load(0, 12'h555);
        rst_n = 1'b0;
        tick(2);
        chk("R1 off during mid-run reset", 10'h000);
        rst_n = 1'b1;
        tick(R + 1);
        chk("R12 registers cleared to pin mode", 10'h3F7);
        commit();
        chk("R12 staged copy cleared too", 10'h3F7);
    endtask

    initial begin
        t_reset_start();
        t_direct_r2();
        t_staged_r6();
        t_and_r5();
        t_level_r4();
        t_tie_r8();
        t_enable_r9();
        t_fault_r11();
        t_reset_clear_r12();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule